// File: doc/BRIEF.md
# Central and Local Beat Timing Generator

This block paces a synchronous controller. Every instruction runs through three machine cycles: fetch, operand and execute. Each machine cycle is a fixed train of central beats, one beat per clock, shown on a one-hot vector. Most instructions finish inside this uniform rhythm.

An instruction flagged as complex gets a run of local beats spliced into its execute cycle, directly after the first execute beat. A local beat is one clock wide, the same width as a central beat. The central train picks up again at the second execute beat once the run ends, so the whole machine keeps one rhythm. The client of the local beats is an unsigned add-and-shift multiplier that does one iteration per local beat. The number of iterations is latched with the start request. A single-clock completion pulse follows the last execute beat.

Top module: `beat_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, phase is 0 (idle), beat_vec is all zero, local_beat is 0, done is 0 and product is 0.
- R2: start is sampled only while phase is idle, including the done cycle. When start is high during any other phase, the beat, phase and product sequence is unchanged.
- R3: While a central beat is active, beat_vec is one-hot. Bit i marks beat Ti. The beats advance T0, T1, T2, T3, one per clock.
- R4: Phase encoding is 1 = fetch, 2 = operand, 3 = execute. Fetch begins in the clock after start is accepted. Fetch and operand each last exactly four central beats, back to back.
- R5: With complex_op low at start, execute is four central beats, local_beat never rises, and the instruction occupies exactly 12 beat clocks.
- R6: With complex_op high at start, execute T0 is followed at once by k local beats. During these, local_beat is 1, beat_vec is zero and phase stays 3. Then T1..T3 follow with no gap.
- R7: k equals iter_count as latched at the accepted start. A latched value of 0, or a value above N, gives k = N.
- R8: done is high for exactly one clock, in the clock after execute T3. Phase is idle in that clock.
- R9: For a complex instruction with k = N, product equals mcand * mplier (unsigned, 2N bits) from execute T1 onward. It holds that value until the next complex start.
- R10: For a complex instruction with k < N, the final product is (mcand * (mplier mod 2^k)) * 2^(N-k) + (mplier >> k).
- R11: A simple instruction leaves product unchanged. For a complex instruction, product reads the zero-extended mplier from fetch T0 through execute T0.
- R12: Outside idle, exactly one of the five beat lines (beat_vec bits and local_beat) is high in every clock. In idle, all of them are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| complex_op | input | 1 | Decode flag: insert local beats in execute |
| iter_count | input | $clog2(N+1) | Number of local beats (0 or >N means N) |
| mcand | input | N | Multiplicand, latched with a complex start |
| mplier | input | N | Multiplier, latched with a complex start |
| beat_vec | output | 4 | One-hot central beat T0..T3 |
| local_beat | output | 1 | Local beat strobe |
| phase | output | 2 | 0 idle, 1 fetch, 2 operand, 3 execute |
| done | output | 1 | One-clock completion pulse |
| product | output | 2N | Multiplier accumulator / result |

## Verification
A corrupted beat index or phase register shows up on beat_vec or phase within the same clock. The reference model follows the exact beat position, so even one slip is flagged at once. A wrong local counter stretches or shortens the local run. That moves T1 and done off their expected clocks, and it changes the product that becomes visible at execute T1. A lost complex flag drops the whole local run, which shows in the first clock after execute T0.

// File: rtl/beat_pkg.sv
package beat_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_OPND  = 2'd2,
    PH_EXEC  = 2'd3
  } phase_e;
endpackage

// File: rtl/beat_sequencer.sv
module beat_sequencer
  import beat_pkg::*;
#(
  parameter int N     = 8,
  parameter int BEATS = 4,
  localparam int BW   = $clog2(BEATS),
  localparam int CW   = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          complex_op,
  input  logic [CW-1:0] iter_count,
  output phase_e        phase_o,
  output logic [BW-1:0] beat_idx_o,
  output logic          central_on_o,
  output logic          local_o,
  output logic          load_o,
  output logic          done_o
);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  phase_e        phase_q;
  logic [BW-1:0] beat_q;
  logic          loc_q, cplx_q, done_q;
  logic [CW-1:0] lcnt_q, k_q, k_eff;

  // zero or out-of-range counts fall back to the full width
  assign k_eff = (iter_count == '0 || int'(iter_count) > N) ? CW'(N) : iter_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      beat_q  <= '0;
      loc_q   <= 1'b0;
      lcnt_q  <= '0;
      cplx_q  <= 1'b0;
      k_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_FETCH;
            beat_q  <= '0;
            cplx_q  <= complex_op;
            k_q     <= k_eff;
          end
        end
        PH_FETCH, PH_OPND: begin
          if (beat_q == LAST) begin
            phase_q <= phase_e'(phase_q + 2'd1);
            beat_q  <= '0;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        PH_EXEC: begin
          if (loc_q) begin
            if (lcnt_q == CW'(1)) begin
              loc_q  <= 1'b0;
              beat_q <= BW'(1);
            end else begin
              lcnt_q <= lcnt_q - 1'b1;
            end
          end else if (beat_q == '0 && cplx_q) begin
            loc_q  <= 1'b1;
            lcnt_q <= k_q;
          end else if (beat_q == LAST) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o      = phase_q;
  assign beat_idx_o   = beat_q;
  assign central_on_o = (phase_q != PH_IDLE) && !loc_q;
  assign local_o      = loc_q;
  assign load_o       = (phase_q == PH_IDLE) && start && complex_op;
  assign done_o       = done_q;
endmodule

// File: rtl/beat_decoder.sv
module beat_decoder #(
  parameter int BEATS = 4,
  localparam int BW   = $clog2(BEATS)
) (
  input  logic [BW-1:0]    idx,
  input  logic             en,
  output logic [BEATS-1:0] vec
);
  for (genvar i = 0; i < BEATS; i++) begin : g_beat
    assign vec[i] = en && (idx == BW'(i));
  end
endmodule

// File: rtl/addshift_mul.sv
module addshift_mul #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic [2*N-1:0] product
);
  logic [N-1:0]   mc_q;
  logic [2*N-1:0] p_q;
  logic [N:0]     sum;

  assign sum = {1'b0, p_q[2*N-1:N]} + (p_q[0] ? {1'b0, mc_q} : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= '0;
      p_q  <= '0;
    end else if (load) begin
      mc_q <= mcand;
      p_q  <= {{N{1'b0}}, mplier};
    end else if (step) begin
      p_q <= {sum, p_q[N-1:1]};
    end
  end

  assign product = p_q;
endmodule

// File: rtl/beat_seq_top.sv
module beat_seq_top
  import beat_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  complex_op,
  input  logic [$clog2(N+1)-1:0] iter_count,
  input  logic [N-1:0]          mcand,
  input  logic [N-1:0]          mplier,
  output logic [3:0]            beat_vec,
  output logic                  local_beat,
  output logic [1:0]            phase,
  output logic                  done,
  output logic [2*N-1:0]        product
);
  localparam int BEATS = 4;
  localparam int BW    = $clog2(BEATS);

  phase_e        ph;
  logic [BW-1:0] idx;
  logic          cen, loc, load;

  beat_sequencer #(.N(N), .BEATS(BEATS)) seq_i (
    .clk(clk), .rst(rst), .start(start), .complex_op(complex_op),
    .iter_count(iter_count), .phase_o(ph), .beat_idx_o(idx),
    .central_on_o(cen), .local_o(loc), .load_o(load), .done_o(done)
  );

  beat_decoder #(.BEATS(BEATS)) dec_i (.idx(idx), .en(cen), .vec(beat_vec));

  addshift_mul #(.N(N)) mul_i (
    .clk(clk), .rst(rst), .load(load), .step(loc),
    .mcand(mcand), .mplier(mplier), .product(product)
  );

  assign local_beat = loc;
  assign phase      = ph;
endmodule

// File: rtl/beat_seq_chk.sv
module beat_seq_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           complex_op,
  input logic [3:0]     beat_vec,
  input logic           local_beat,
  input logic [1:0]     phase,
  input logic           done,
  input logic [2*N-1:0] product
);
  a_r12_one_beat: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd0) |-> $countones({beat_vec, local_beat}) == 1);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0) |-> (beat_vec == 4'd0 && !local_beat));

  a_r3_t1_order: assert property (@(posedge clk) disable iff (rst)
    beat_vec[1] |-> ($past(beat_vec[0]) || $past(local_beat)));

  a_r3_t2_order: assert property (@(posedge clk) disable iff (rst)
    beat_vec[2] |-> $past(beat_vec[1]));

  a_r3_t3_order: assert property (@(posedge clk) disable iff (rst)
    beat_vec[3] |-> $past(beat_vec[2]));

  a_r6_local_in_exec: assert property (@(posedge clk) disable iff (rst)
    local_beat |-> (phase == 2'd3 && ($past(local_beat) || $past(beat_vec[0]))));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_t3: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase == 2'd0 && $past(phase == 2'd3 && beat_vec[3])));

  a_r11_product_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!local_beat && !(start && phase == 2'd0 && complex_op)) |-> $stable(product));
endmodule

bind beat_seq_top beat_seq_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .start(start), .complex_op(complex_op),
  .beat_vec(beat_vec), .local_beat(local_beat), .phase(phase),
  .done(done), .product(product)
);

// File: tb/beat_seq_top_tb_top.sv
module beat_seq_top_tb_top;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, complex_op = 1'b0;
  logic [CW-1:0] iter_count = '0;
  logic [N-1:0] mcand = '0, mplier = '0;
  logic [3:0] beat_vec;
  logic local_beat, done;
  logic [1:0] phase;
  logic [2*N-1:0] product;

  int checks = 0, errors = 0, cycles = 0;
  string req = "R1";

  always #5 clk = ~clk;

  beat_seq_top #(.N(N)) dut_i (.*);

  // behavioural reference: position within the instruction
  bit busy = 0, m_cplx = 0, m_done = 0;
  int pos = 0, m_k = 0;
  longint m_prod = 0, m_final = 0;

  function automatic longint ref_prod(longint a, longint b, int k);
    return ((a * (b % (64'd1 << k))) << (N - k)) + (b >> k);
  endfunction

  function automatic int len_of(bit c, int k);
    return 12 + (c ? k : 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      busy = 0; m_done = 0; m_prod = 0; pos = 0;
    end else begin
      m_done = 0;
      if (!busy) begin
        if (start) begin
          busy = 1; pos = 0; m_cplx = complex_op;
          m_k = (iter_count == 0 || int'(iter_count) > N) ? N : int'(iter_count);
          if (complex_op) begin
            m_prod  = longint'(mplier);
            m_final = ref_prod(longint'(mcand), longint'(mplier), m_k);
          end
        end
      end else if (pos == len_of(m_cplx, m_k) - 1) begin
        busy = 0; m_done = 1;
      end else begin
        if (m_cplx && pos == 8 + m_k) m_prod = m_final;
        pos++;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", tag, req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e_ph, e_beat;
    bit e_loc;
    cycles++;
    if (!rst) begin
      e_ph = 0; e_beat = 0; e_loc = 0;
      if (busy) begin
        e_ph = (pos < 4) ? 1 : (pos < 8) ? 2 : 3;
        e_loc = m_cplx && pos >= 9 && pos <= 8 + m_k;
        if (pos < 8) e_beat = 1 << (pos % 4);
        else if (pos == 8) e_beat = 1;
        else if (!e_loc) e_beat = 1 << (pos - 8 - (m_cplx ? m_k : 0));
      end
      chk("R4 phase", phase, e_ph);
      chk("R3 beat", beat_vec, e_beat);
      chk("R6 local", local_beat, e_loc);
      chk("R8 done", done, m_done);
      chk("R12 exclusive", (beat_vec != 0) && local_beat, 0);
      if (!e_loc) chk("R9/R11 product", product, m_prod);
    end
  end

  // drive one instruction; returns in the done cycle
  task automatic run(bit c, int it, int a, int b, bit hold);
    int l;
    l = len_of(c, (it == 0 || it > N) ? N : it);
    start = 1; complex_op = c; iter_count = CW'(it);
    mcand = N'(a); mplier = N'(b);
    @(negedge clk);
    if (!hold) start = 0;
    repeat (l - 1) @(negedge clk);
    start = 0;
    complex_op = ~c; mcand = N'(~a); mplier = N'(~b);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    req = "R1";
    chk("R1 phase", phase, 0);
    chk("R1 beat", beat_vec, 0);
    chk("R1 local", local_beat, 0);
    chk("R1 done", done, 0);
    chk("R1 product", product, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {product, phase, beat_vec, local_beat, done}, 0);

    req = "R5"; run(0, 5, 3, 7, 0); repeat (2) @(negedge clk);
    req = "R9"; run(1, 0, 255, 255, 0);
    chk("R9 full product", product, 255 * 255);
    repeat (2) @(negedge clk);
    req = "R9"; run(1, 8, 13, 11, 0); chk("R9 product", product, 143);
    req = "R10"; run(1, 3, 200, 173, 0);
    chk("R10 partial", product, ref_prod(200, 173, 3));
    req = "R7"; run(1, 12, 9, 250, 0); chk("R7 clamp", product, 9 * 250);
    req = "R7"; run(1, 1, 77, 5, 0);
    req = "R11"; run(0, 2, 1, 1, 0); chk("R11 unchanged", product, ref_prod(77, 5, 1));
    req = "R2"; run(1, 4, 170, 85, 1); repeat (2) @(negedge clk);
    req = "R2"; run(0, 0, 0, 0, 1);
    req = "R6"; run(1, 2, 255, 129, 0); run(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++; checks++;
    $display("FAIL watchdog (%s) actual=hung expected=finished", req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule